// File: doc/BRIEF.md
# Pipeline hazard controller

This block decides, every cycle, whether the instruction in the register-read stage of a five-stage in-order pipeline (fetch, decode, register read, ALU, write-back) may advance. It compares the source register numbers of that instruction with the destination numbers of the two older instructions still in flight, in the ALU and write-back stages. From that comparison it either raises a stall, or it produces operand forward selects that steer the ALU operand multiplexers one cycle later.

The ALU stage also reports whether a branch there has resolved taken. When it has, the controller raises a redirect and kills the younger instructions that were fetched down the wrong path. The register-read instruction is among them, unless delay-slot mode is on, in which case that instruction is kept and executes normally. Two plain configuration pins select forwarding on or off and delay-slot mode on or off. None of the pins carries streaming data, so no valid/ready handshake is used: all pins are level control signals sampled each cycle.

Top module: `hazard_ctl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both forward selects read 2'b00 (register file).
- R2: A source naming register 0 never produces a stall and never produces a forward select other than 2'b00.
- R3: With forwarding off, a valid read-stage instruction whose used, nonzero source equals the destination of a valid writing instruction in the ALU or write-back stage raises stall and bubble_ex in that same cycle, provided no register-read kill is active.
- R4: With forwarding on, data dependencies never raise stall. The forward select registered at the clock edge is 2'b01 (ALU result latch) when the producer was in the ALU stage, and 2'b10 (write-back result latch) when it was only in the write-back stage.
- R5: When both the ALU-stage and the write-back-stage instructions write the same source register, the younger ALU-stage producer wins and the select is 2'b01.
- R6: A source with its use bit low, or a producer that is invalid or does not write, creates no dependency.
- R7: redirect equals ex_valid and ex_br_taken, and kill_fetch and kill_decode are raised in that same cycle.
- R8: With delay-slot mode off, a redirect also raises kill_read and bubble_ex and suppresses stall.
- R9: With delay-slot mode on, a redirect leaves kill_read low, so the instruction right after the branch stays; its own stall and forwarding behave as if no branch were present.
- R10: After any cycle with bubble_ex high, or with the read stage invalid, or with forwarding off, both forward selects are 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fwd_en | input | 1 | 1 enables operand forwarding; 0 gives interlock-only stalling |
| cfg_delay_slot | input | 1 | 1 keeps the instruction after a taken branch |
| rd_valid | input | 1 | Register-read stage holds a live instruction |
| rd_src_a | input | REG_W | First source register number |
| rd_use_a | input | 1 | First source is read |
| rd_src_b | input | REG_W | Second source register number |
| rd_use_b | input | 1 | Second source is read |
| ex_valid | input | 1 | ALU stage holds a live instruction |
| ex_wen | input | 1 | ALU-stage instruction writes a register |
| ex_dst | input | REG_W | ALU-stage destination register |
| ex_br_taken | input | 1 | ALU-stage branch resolved taken |
| wb_valid | input | 1 | Write-back stage holds a live instruction |
| wb_wen | input | 1 | Write-back instruction writes a register |
| wb_dst | input | REG_W | Write-back destination register |
| stall | output | 1 | Hold fetch, decode and register read this cycle |
| redirect | output | 1 | Load the branch target into fetch |
| kill_fetch | output | 1 | Clear the fetch-stage valid bit |
| kill_decode | output | 1 | Clear the decode-stage valid bit |
| kill_read | output | 1 | Clear the register-read instruction on its way to the ALU |
| bubble_ex | output | 1 | ALU stage receives an invalid slot next cycle |
| fwd_sel_a | output | 2 | Registered select for ALU operand A (00 file, 01 ALU latch, 10 WB latch) |
| fwd_sel_b | output | 2 | Registered select for ALU operand B, same encoding |

## Verification
The checker takes for granted that its inputs describe a legal pipeline snapshot sampled once per cycle. It assumes the configuration pins only change between cycles, and it assumes that ex_br_taken is meaningful only together with ex_valid. The properties on the registered selects also rely on the inputs being stable across the edge on which they are captured. The stimulus keeps within these assumptions: every input, configuration pins included, changes only at the falling edge. A near-exhaustive sweep with a four-register file walks every combination of configuration, producer validity, write enables, destinations, branch outcome and first source, with the second source derived from the first.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  // Operand source for the ALU stage; codes are decoded by the datapath mux.
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_ALU = 2'b01,
    FWD_WB  = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_OPS = 2;
endpackage

// File: rtl/hazard_src_match.sv
module hazard_src_match
  import hazard_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             use_src,
  input  logic             ex_valid,
  input  logic             ex_wen,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             wb_valid,
  input  logic             wb_wen,
  input  logic [REG_W-1:0] wb_dst,
  output logic             hit_ex,
  output logic             hit_wb,
  output fwd_sel_e         sel
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic live_src;

  // Register zero is hard-wired, so it never creates a dependency.
  assign live_src = use_src && (src != ZERO_REG);
  assign hit_ex   = live_src && ex_valid && ex_wen && (ex_dst == src);
  assign hit_wb   = live_src && wb_valid && wb_wen && (wb_dst == src);

  // The youngest older producer owns the newest value.
  always_comb begin
    if (hit_ex)      sel = FWD_ALU;
    else if (hit_wb) sel = FWD_WB;
    else             sel = FWD_RF;
  end
endmodule

// File: rtl/hazard_branch_ctl.sv
module hazard_branch_ctl (
  input  logic ex_valid,
  input  logic ex_br_taken,
  input  logic delay_slot,
  output logic redirect,
  output logic kill_fetch,
  output logic kill_decode,
  output logic kill_read
);
  assign redirect    = ex_valid && ex_br_taken;
  assign kill_fetch  = redirect;
  assign kill_decode = redirect;
  // In delay-slot mode the instruction just behind the branch survives.
  assign kill_read   = redirect && !delay_slot;
endmodule

// File: rtl/hazard_fwd_reg.sv
module hazard_fwd_reg
  import hazard_pkg::*;
#(
  parameter int unsigned NOPS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic [NOPS*2-1:0]    sel_in,
  output logic [NOPS*2-1:0]    sel_q
);
  for (genvar i = 0; i < NOPS; i++) begin : g_op
    fwd_sel_e q;
    always_ff @(posedge clk) begin
      if (!rst_n)     q <= FWD_RF;
      else if (clear) q <= FWD_RF;
      else            q <= fwd_sel_e'(sel_in[i*2 +: 2]);
    end
    assign sel_q[i*2 +: 2] = q;
  end
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hazard_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_fwd_en,
  input  logic             cfg_delay_slot,
  input  logic             rd_valid,
  input  logic [REG_W-1:0] rd_src_a,
  input  logic             rd_use_a,
  input  logic [REG_W-1:0] rd_src_b,
  input  logic             rd_use_b,
  input  logic             ex_valid,
  input  logic             ex_wen,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_br_taken,
  input  logic             wb_valid,
  input  logic             wb_wen,
  input  logic [REG_W-1:0] wb_dst,
  output logic             stall,
  output logic             redirect,
  output logic             kill_fetch,
  output logic             kill_decode,
  output logic             kill_read,
  output logic             bubble_ex,
  output logic [1:0]       fwd_sel_a,
  output logic [1:0]       fwd_sel_b
);
  localparam int unsigned NOPS = NUM_OPS;

  logic [REG_W-1:0]  src_v [NOPS];
  logic [NOPS-1:0]   use_v;
  logic [NOPS-1:0]   hit_ex_v;
  logic [NOPS-1:0]   hit_wb_v;
  logic [NOPS*2-1:0] sel_v;
  logic [NOPS*2-1:0] sel_q;
  logic              data_hazard;
  logic              clear_sel;

  assign src_v[0] = rd_src_a;
  assign src_v[1] = rd_src_b;
  assign use_v    = {rd_use_b, rd_use_a};

  for (genvar i = 0; i < NOPS; i++) begin : g_cmp
    fwd_sel_e sel_e;
    hazard_src_match #(.REG_W(REG_W)) u_match (
      .src      (src_v[i]),
      .use_src  (use_v[i]),
      .ex_valid (ex_valid),
      .ex_wen   (ex_wen),
      .ex_dst   (ex_dst),
      .wb_valid (wb_valid),
      .wb_wen   (wb_wen),
      .wb_dst   (wb_dst),
      .hit_ex   (hit_ex_v[i]),
      .hit_wb   (hit_wb_v[i]),
      .sel      (sel_e)
    );
    assign sel_v[i*2 +: 2] = sel_e;
  end

  hazard_branch_ctl u_branch (
    .ex_valid    (ex_valid),
    .ex_br_taken (ex_br_taken),
    .delay_slot  (cfg_delay_slot),
    .redirect    (redirect),
    .kill_fetch  (kill_fetch),
    .kill_decode (kill_decode),
    .kill_read   (kill_read)
  );

  // Interlock only when no bypass path exists and the reader survives.
  assign data_hazard = rd_valid && (|hit_ex_v || |hit_wb_v);
  assign stall       = data_hazard && !cfg_fwd_en && !kill_read;
  assign bubble_ex   = stall || kill_read;
  assign clear_sel   = bubble_ex || !rd_valid || !cfg_fwd_en;

  hazard_fwd_reg #(.NOPS(NOPS)) u_fwd (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear_sel),
    .sel_in (sel_v),
    .sel_q  (sel_q)
  );

  assign fwd_sel_a = sel_q[1:0];
  assign fwd_sel_b = sel_q[3:2];
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_fwd_en,
  input logic             cfg_delay_slot,
  input logic             rd_valid,
  input logic [REG_W-1:0] rd_src_a,
  input logic             rd_use_a,
  input logic             ex_valid,
  input logic             ex_wen,
  input logic [REG_W-1:0] ex_dst,
  input logic             ex_br_taken,
  input logic             stall,
  input logic             redirect,
  input logic             kill_fetch,
  input logic             kill_decode,
  input logic             kill_read,
  input logic             bubble_ex,
  input logic [1:0]       fwd_sel_a,
  input logic [1:0]       fwd_sel_b
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  assert_src0_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_src_a == ZERO_REG) |=> (fwd_sel_a == 2'b00));

  assert_no_stall_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fwd_en |-> !stall);

  assert_alu_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fwd_en && rd_valid && rd_use_a && rd_src_a != ZERO_REG && ex_valid && ex_wen
     && ex_dst == rd_src_a && !bubble_ex) |=> (fwd_sel_a == 2'b01));

  assert_kill_young_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_br_taken) |-> (redirect && kill_fetch && kill_decode));

  assert_kill_nostall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kill_read |-> (!stall && bubble_ex));

  assert_keep_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && cfg_delay_slot) |-> !kill_read);

  assert_bubble_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_ex |=> (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00));
endmodule

bind hazard_ctl hazard_ctl_chk #(.REG_W(REG_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_fwd_en     (cfg_fwd_en),
  .cfg_delay_slot (cfg_delay_slot),
  .rd_valid       (rd_valid),
  .rd_src_a       (rd_src_a),
  .rd_use_a       (rd_use_a),
  .ex_valid       (ex_valid),
  .ex_wen         (ex_wen),
  .ex_dst         (ex_dst),
  .ex_br_taken    (ex_br_taken),
  .stall          (stall),
  .redirect       (redirect),
  .kill_fetch     (kill_fetch),
  .kill_decode    (kill_decode),
  .kill_read      (kill_read),
  .bubble_ex      (bubble_ex),
  .fwd_sel_a      (fwd_sel_a),
  .fwd_sel_b      (fwd_sel_b)
);

// File: tb/hazard_ctl_tb.sv
module hazard_ctl_tb_top;
  localparam int unsigned RW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_fwd_en = 1'b0, cfg_delay_slot = 1'b0;
  logic rd_valid = 1'b0, rd_use_a = 1'b0, rd_use_b = 1'b0;
  logic [RW-1:0] rd_src_a = '0, rd_src_b = '0, ex_dst = '0, wb_dst = '0;
  logic ex_valid = 1'b0, ex_wen = 1'b0, ex_br_taken = 1'b0;
  logic wb_valid = 1'b0, wb_wen = 1'b0;
  logic stall, redirect, kill_fetch, kill_decode, kill_read, bubble_ex;
  logic [1:0] fwd_sel_a, fwd_sel_b;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hazard_ctl #(.REG_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_fwd_en(cfg_fwd_en), .cfg_delay_slot(cfg_delay_slot),
    .rd_valid(rd_valid), .rd_src_a(rd_src_a), .rd_use_a(rd_use_a),
    .rd_src_b(rd_src_b), .rd_use_b(rd_use_b),
    .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_dst(ex_dst), .ex_br_taken(ex_br_taken),
    .wb_valid(wb_valid), .wb_wen(wb_wen), .wb_dst(wb_dst),
    .stall(stall), .redirect(redirect), .kill_fetch(kill_fetch),
    .kill_decode(kill_decode), .kill_read(kill_read), .bubble_ex(bubble_ex),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit dep(input logic [RW-1:0] s, input bit u, input bit v,
                             input bit w, input logic [RW-1:0] d);
    return u && (s != 0) && v && w && (d == s);
  endfunction

  function automatic string sel_tag(input logic [RW-1:0] s, input bit u, input bit e,
                                    input bit wbh, input bit cleared);
    if (cleared)     return "R10";
    if (s == 0)      return "R2";
    if (!u)          return "R6";
    if (e && wbh)    return "R5";
    return "R4";
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : stim
    // R1: reset holds selects at register file even with forwardable inputs.
    cfg_fwd_en = 1'b1; rd_valid = 1'b1; rd_use_a = 1'b1; rd_src_a = 2'd1;
    ex_valid = 1'b1; ex_wen = 1'b1; ex_dst = 2'd1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 fwd_sel_a in reset", int'(fwd_sel_a), 0);
    check("R1 fwd_sel_b in reset", int'(fwd_sel_b), 0);
    @(negedge clk);
    rst_n = 1'b1;
    ex_valid = 1'b0;
    @(posedge clk); #1;
    check("R1 fwd_sel_a after reset", int'(fwd_sel_a), 0);

    for (int v = 0; v < 32768; v++) begin
      bit fe, ds, rv, ua, ev, ew, wv, ww, br;
      logic [RW-1:0] sa, sb, ed, wd;
      bit ae, aw, be, bw, e_red, e_kr, e_stall, e_bub, clr;
      int e_fa, e_fb;
      string tg;
      @(negedge clk);
      fe = v[0]; ds = v[1]; rv = v[2]; ua = v[3]; ev = v[4]; ew = v[5];
      wv = v[6]; ww = v[7]; br = v[8];
      sa = v[10:9]; ed = v[12:11]; wd = v[14:13];
      sb = ~sa;
      cfg_fwd_en = fe; cfg_delay_slot = ds; rd_valid = rv;
      rd_src_a = sa; rd_use_a = ua; rd_src_b = sb; rd_use_b = 1'b1;
      ex_valid = ev; ex_wen = ew; ex_dst = ed; ex_br_taken = br;
      wb_valid = wv; wb_wen = ww; wb_dst = wd;

      ae = dep(sa, ua, ev, ew, ed);   aw = dep(sa, ua, wv, ww, wd);
      be = dep(sb, 1'b1, ev, ew, ed); bw = dep(sb, 1'b1, wv, ww, wd);
      e_red   = ev && br;
      e_kr    = e_red && !ds;
      e_stall = rv && (ae || aw || be || bw) && !fe && !e_kr;
      e_bub   = e_stall || e_kr;
      clr     = e_bub || !rv || !fe;
      e_fa = clr ? 0 : (ae ? 1 : (aw ? 2 : 0));
      e_fb = clr ? 0 : (be ? 1 : (bw ? 2 : 0));

      #1;
      check(fe ? "R4 no stall with forwarding" : (e_kr ? "R8 stall suppressed" : "R3 stall"),
            int'(stall), int'(e_stall));
      check(e_kr ? "R8 bubble_ex" : "R3 bubble_ex", int'(bubble_ex), int'(e_bub));
      check("R7 redirect", int'(redirect), int'(e_red));
      check("R7 kill_fetch/decode", int'(kill_fetch && kill_decode), int'(e_red));
      check(ds ? "R9 kill_read" : "R8 kill_read", int'(kill_read), int'(e_kr));
      @(posedge clk);
      #1;
      tg = sel_tag(sa, ua, ae, aw, clr);
      check({tg, " fwd_sel_a"}, int'(fwd_sel_a), e_fa);
      tg = sel_tag(sb, 1'b1, be, bw, clr);
      check({tg, " fwd_sel_b"}, int'(fwd_sel_b), e_fb);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule